// File: doc/BRIEF.md
# Frame Schedule Player with Validity Checker

This block holds the connection frame of a load-balanced switch fabric. A frame has N time-slots. In each slot, every sending linecard is told which receiving linecard its crossbar output goes to. The block replays the active frame forever, one slot per clock, and drives one select value per sender. A new frame is needed only when linecards are added or removed. Software or a configuration engine writes it entry by entry into a shadow copy, writes the group number of every linecard into a membership table, and then pulses a commit strobe.

On commit, a checker walks the shadow frame one slot per cycle. It confirms that every slot sends each sender to a distinct, existing receiver, and that over the whole frame every sender reaches every receiver exactly once. It also confirms the inter-group limit: in any single slot, the number of senders of group i that target receivers of group j must not exceed ceil(Li·Lj/N), where Li is the population of group i. This limit is the capacity of the static optical paths between the two groups. A frame that passes is copied into the active store at the next frame boundary. A frame that fails raises the error flag and leaves the running frame untouched.

Top module: `lbs_frame_player`

## Requirements
- R1: While reset is held and directly after it, valid, error and busy are 0, the slot index is 0 and every select output is 0.
- R2: The slot index counts 0,1,…,N-1 and wraps to 0, advancing once per clock. The frame-start flag is high exactly when the slot index is 0.
- R3: The select output of sender s equals the receiver stored for sender s in the current slot of the active frame. Before any frame has been activated, the active frame holds all zeros.
- R4: A commit taken while idle starts a check that scans exactly N slots. Busy is high for exactly N cycles before the verdict on a failing frame. On a passing frame, busy stays high until the frame is activated.
- R5: A frame fails unless, in every slot, all N receiver codes are below N and pairwise distinct, and every sender is assigned each of the N receivers exactly once across the frame.
- R6: A frame fails if, in any slot, the count of senders in group i aimed at receivers in group j exceeds ceil(Li·Lj/N). Group ids are 0..G-1. After reset, every linecard is in group 0. A membership write with id ≥ G is ignored.
- R7: On a failed check, the error flag rises and busy falls on the same edge, and the active frame and valid stay unchanged. The error flag clears when the next commit is accepted.
- R8: A passing frame becomes active on the clock edge where the slot index wraps from N-1 to 0, and valid is then 1. Busy falls on that same edge.
- R9: While busy, shadow-frame writes, membership writes and commit strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Shadow-frame entry write strobe |
| wr_slot | input | $clog2(N_LC) | Slot of the entry written |
| wr_sender | input | $clog2(N_LC) | Sender of the entry written |
| wr_dest | input | $clog2(N_LC) | Receiver code stored in the entry |
| grp_wr_en | input | 1 | Membership table write strobe |
| grp_wr_lc | input | $clog2(N_LC) | Linecard whose group is written |
| grp_wr_id | input | GW | Group id (GW = $clog2(N_GRP), at least 1) |
| commit | input | 1 | Start checking the shadow frame |
| sel_o | output | N_LC*$clog2(N_LC) | Per-sender receiver select; sender s at bits [s*LW +: LW] |
| slot_o | output | $clog2(N_LC) | Current slot index |
| frame_start_o | output | 1 | High in slot 0 |
| busy_o | output | 1 | Check running or passing frame waiting for a boundary |
| valid_o | output | 1 | An active frame has been installed |
| err_o | output | 1 | Last check failed |

## Verification
The hardest case to reach from the ports is a frame that is a perfect Latin square but breaks the per-slot group-pair limit. Whether that happens depends on how the membership table lines up with the frame's rotation, not on any single entry. The bench therefore sweeps every assignment of six linecards to three groups. For each one it loads a rotated Latin frame with a varying multiplier and offset, and computes the expected verdict arithmetically. Some assignments also carry a deliberately corrupted entry. During passing checks, the bench injects writes and commits while busy, and it offers an out-of-range group id. The frame played afterwards shows whether any of these leaked in.

// File: rtl/lbs_sched_pkg.sv
// Package: shared types and helpers for the frame schedule player.
// Assumes: nothing beyond IEEE 1800-2017 integer arithmetic.
package lbs_sched_pkg;

    // Checker sequencing states
    typedef enum logic [1:0] {
        CK_IDLE = 2'd0,
        CK_SCAN = 2'd1,
        CK_HOLD = 2'd2
    } ck_state_e;

    // Integer division rounded up
    function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/lbs_group_table.sv
// Module: group membership table.
// Holds the group id of every linecard, derives group populations and
// the per-slot capacity ceil(Li*Lj/N) for every group pair.
// Assumes: writes are blocked by lock_i while a check is in flight.
module lbs_group_table
    import lbs_sched_pkg::*;
#(
    parameter  int N_LC  = 6,
    parameter  int N_GRP = 3,
    localparam int LW    = $clog2(N_LC),
    localparam int GW    = (N_GRP > 1) ? $clog2(N_GRP) : 1,
    localparam int CW    = $clog2(N_LC + 1)
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      lock_i,
    input  logic                                      wr_en_i,
    input  logic [LW-1:0]                             wr_lc_i,
    input  logic [GW-1:0]                             wr_id_i,
    output logic [N_LC-1:0][GW-1:0]                   grp_o,
    output logic [N_GRP-1:0][N_GRP-1:0][CW-1:0]       cap_o
);

    logic [N_LC-1:0][GW-1:0] grp_q;
    int unsigned             size_c [N_GRP];
    logic                    ids_ok;

    // Store a group id; reject locked, out-of-range linecard or id
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_q <= '0;
        end else if (wr_en_i && !lock_i && (int'(wr_lc_i) < N_LC) && (int'(wr_id_i) < N_GRP)) begin
            grp_q[wr_lc_i] <= wr_id_i;
        end
    end

    // Count linecards per group
    always_comb begin
        for (int g = 0; g < N_GRP; g++) begin
            size_c[g] = 0;
            for (int l = 0; l < N_LC; l++) begin
                if (grp_q[l] == GW'(g)) size_c[g] = size_c[g] + 1;
            end
        end
    end

    // Capacity per group pair, rounded up
    always_comb begin
        for (int i = 0; i < N_GRP; i++) begin
            for (int j = 0; j < N_GRP; j++) begin
                cap_o[i][j] = CW'(ceil_div(size_c[i] * size_c[j], N_LC));
            end
        end
    end

    // Flag that every stored id names an existing group
    always_comb begin
        ids_ok = 1'b1;
        for (int l = 0; l < N_LC; l++) begin
            if (int'(grp_q[l]) >= N_GRP) ids_ok = 1'b0;
        end
    end

    assign grp_o = grp_q;

    AST_GROUP_ID_RANGE: assert property (@(posedge clk) disable iff (!rst_n) ids_ok); // R6

endmodule

// File: rtl/lbs_frame_store.sv
// Module: shadow and active frame storage plus slot sequencer.
// Entry [slot][sender] holds a receiver code. The active copy is replayed
// one slot per clock; the shadow copy is taken over on swap_i, which the
// checker raises only in the last slot of a frame.
// Assumes: swap_i coincides with bound_o.
module lbs_frame_store #(
    parameter  int N_LC = 6,
    localparam int LW   = $clog2(N_LC)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           lock_i,
    input  logic                           wr_en_i,
    input  logic [LW-1:0]                  wr_slot_i,
    input  logic [LW-1:0]                  wr_snd_i,
    input  logic [LW-1:0]                  wr_dst_i,
    input  logic [LW-1:0]                  rd_slot_i,
    input  logic                           swap_i,
    output logic [N_LC-1:0][LW-1:0]        col_o,
    output logic [N_LC-1:0][LW-1:0]        sel_o,
    output logic [LW-1:0]                  slot_o,
    output logic                           bound_o,
    output logic                           valid_o
);

    localparam logic [LW-1:0] LAST_SLOT = LW'(N_LC - 1);

    logic [N_LC-1:0][N_LC-1:0][LW-1:0] shadow_q;
    logic [N_LC-1:0][N_LC-1:0][LW-1:0] active_q;
    logic [LW-1:0]                     slot_q;
    logic                              valid_q;

    // Shadow entry write, blocked while a check is in flight
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (wr_en_i && !lock_i && (int'(wr_slot_i) < N_LC) && (int'(wr_snd_i) < N_LC)) begin
            shadow_q[wr_slot_i][wr_snd_i] <= wr_dst_i;
        end
    end

    // Active frame takes the shadow on swap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= '0;
            valid_q  <= 1'b0;
        end else if (swap_i) begin
            active_q <= shadow_q;
            valid_q  <= 1'b1;
        end
    end

    // Free-running slot index, wraps at N-1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else if (slot_q == LAST_SLOT) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_q + LW'(1);
        end
    end

    assign col_o   = shadow_q[rd_slot_i];
    assign sel_o   = active_q[slot_q];
    assign slot_o  = slot_q;
    assign bound_o = (slot_q == LAST_SLOT);
    assign valid_o = valid_q;

    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(slot_q) < N_LC); // R2
    AST_ACTIVE_ONLY_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active_q) |-> ($past(slot_q) == LAST_SLOT && slot_q == '0)); // R8
    AST_SHADOW_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        lock_i |=> $stable(shadow_q)); // R9

endmodule

// File: rtl/lbs_frame_checker.sv
// Module: frame validity checker and activation sequencer.
// One slot per cycle: tests the slot for distinct in-range receivers,
// tallies the group-pair count against capacity, and accumulates a
// per-sender mask of receivers reached. After N passes it either holds
// the result until the frame boundary (pass) or flags an error (fail).
// Assumes: col_i follows rd_slot_o combinationally.
module lbs_frame_checker
    import lbs_sched_pkg::*;
#(
    parameter  int N_LC  = 6,
    parameter  int N_GRP = 3,
    localparam int LW    = $clog2(N_LC),
    localparam int GW    = (N_GRP > 1) ? $clog2(N_GRP) : 1,
    localparam int CW    = $clog2(N_LC + 1)
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  start_i,
    input  logic [N_LC-1:0][LW-1:0]               col_i,
    input  logic [N_LC-1:0][GW-1:0]               grp_i,
    input  logic [N_GRP-1:0][N_GRP-1:0][CW-1:0]   cap_i,
    input  logic                                  bound_i,
    output logic [LW-1:0]                         rd_slot_o,
    output logic                                  busy_o,
    output logic                                  err_o,
    output logic                                  swap_o
);

    localparam logic [LW-1:0] LAST_PASS = LW'(N_LC - 1);

    ck_state_e                   state_q;
    logic [LW-1:0]               pass_q;
    logic [N_LC-1:0][N_LC-1:0]   row_q;
    logic [N_LC-1:0][N_LC-1:0]   row_nxt;
    logic                        bad_q;
    logic                        err_q;
    logic                        col_bad;
    logic                        grp_bad;
    logic                        rows_full;
    logic                        scan_ok;

    // Column test: every receiver code in range and used at most once
    always_comb begin
        logic [N_LC-1:0] seen;
        seen    = '0;
        col_bad = 1'b0;
        for (int s = 0; s < N_LC; s++) begin
            if (int'(col_i[s]) >= N_LC) begin
                col_bad = 1'b1;
            end else begin
                if (seen[col_i[s]]) col_bad = 1'b1;
                seen[col_i[s]] = 1'b1;
            end
        end
    end

    // Group-pair tally for this slot against its capacity
    always_comb begin
        grp_bad = 1'b0;
        for (int i = 0; i < N_GRP; i++) begin
            for (int j = 0; j < N_GRP; j++) begin
                int cnt;
                cnt = 0;
                for (int s = 0; s < N_LC; s++) begin
                    if (grp_i[s] == GW'(i) && int'(col_i[s]) < N_LC) begin
                        if (grp_i[col_i[s]] == GW'(j)) cnt = cnt + 1;
                    end
                end
                if (cnt > int'(cap_i[i][j])) grp_bad = 1'b1;
            end
        end
    end

    // Receivers reached per sender, including this slot
    always_comb begin
        for (int s = 0; s < N_LC; s++) begin
            row_nxt[s] = row_q[s];
            if (int'(col_i[s]) < N_LC) row_nxt[s][col_i[s]] = 1'b1;
        end
    end

    // Every sender has reached every receiver
    always_comb begin
        rows_full = 1'b1;
        for (int s = 0; s < N_LC; s++) begin
            if (row_nxt[s] != '1) rows_full = 1'b0;
        end
    end

    assign scan_ok = !bad_q && !col_bad && !grp_bad && rows_full;

    // Check sequencing: start, scan N slots, hold for boundary or flag error
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CK_IDLE;
            pass_q  <= '0;
            row_q   <= '0;
            bad_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            case (state_q)
                CK_IDLE: begin
                    if (start_i) begin
                        state_q <= CK_SCAN;
                        pass_q  <= '0;
                        row_q   <= '0;
                        bad_q   <= 1'b0;
                        err_q   <= 1'b0;
                    end
                end
                CK_SCAN: begin
                    row_q <= row_nxt;
                    bad_q <= bad_q | col_bad | grp_bad;
                    if (pass_q == LAST_PASS) begin
                        if (scan_ok) begin
                            state_q <= CK_HOLD;
                        end else begin
                            state_q <= CK_IDLE;
                            err_q   <= 1'b1;
                        end
                    end else begin
                        pass_q <= pass_q + LW'(1);
                    end
                end
                CK_HOLD: begin
                    if (bound_i) state_q <= CK_IDLE;
                end
                default: state_q <= CK_IDLE;
            endcase
        end
    end

    assign rd_slot_o = pass_q;
    assign busy_o    = (state_q != CK_IDLE);
    assign err_o     = err_q;
    assign swap_o    = (state_q == CK_HOLD) && bound_i;

    AST_PASS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CK_SCAN) |-> (int'(pass_q) < N_LC)); // R4
    AST_HOLD_AFTER_FULL_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CK_HOLD && $past(state_q) == CK_SCAN) |-> ($past(pass_q) == LAST_PASS)); // R4
    AST_ERR_AT_SCAN_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> ($past(state_q) == CK_SCAN && $past(pass_q) == LAST_PASS && state_q == CK_IDLE)); // R7
    AST_SWAP_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        swap_o |=> (state_q == CK_IDLE && !err_q)); // R8

endmodule

// File: rtl/lbs_frame_player.sv
// Module: top level of the frame schedule player with validity checker.
// Wires the group table, frame store and checker together and flattens
// the per-sender selects onto one output vector.
// Assumes: inputs are synchronous to clk; N_LC >= 2.
module lbs_frame_player #(
    parameter  int N_LC  = 6,
    parameter  int N_GRP = 3,
    localparam int LW    = $clog2(N_LC),
    localparam int GW    = (N_GRP > 1) ? $clog2(N_GRP) : 1,
    localparam int CW    = $clog2(N_LC + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [LW-1:0]        wr_slot,
    input  logic [LW-1:0]        wr_sender,
    input  logic [LW-1:0]        wr_dest,
    input  logic                 grp_wr_en,
    input  logic [LW-1:0]        grp_wr_lc,
    input  logic [GW-1:0]        grp_wr_id,
    input  logic                 commit,
    output logic [N_LC*LW-1:0]   sel_o,
    output logic [LW-1:0]        slot_o,
    output logic                 frame_start_o,
    output logic                 busy_o,
    output logic                 valid_o,
    output logic                 err_o
);

    logic [N_LC-1:0][GW-1:0]                 grp_w;
    logic [N_GRP-1:0][N_GRP-1:0][CW-1:0]     cap_w;
    logic [N_LC-1:0][LW-1:0]                 col_w;
    logic [N_LC-1:0][LW-1:0]                 sel_w;
    logic [LW-1:0]                           rd_slot_w;
    logic [LW-1:0]                           slot_w;
    logic                                    bound_w;
    logic                                    swap_w;
    logic                                    busy_w;
    logic                                    valid_w;
    logic                                    sel_in_range;

    lbs_group_table #(.N_LC(N_LC), .N_GRP(N_GRP)) u_groups (
        .clk     (clk),
        .rst_n   (rst_n),
        .lock_i  (busy_w),
        .wr_en_i (grp_wr_en),
        .wr_lc_i (grp_wr_lc),
        .wr_id_i (grp_wr_id),
        .grp_o   (grp_w),
        .cap_o   (cap_w)
    );

    lbs_frame_store #(.N_LC(N_LC)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock_i    (busy_w),
        .wr_en_i   (wr_en),
        .wr_slot_i (wr_slot),
        .wr_snd_i  (wr_sender),
        .wr_dst_i  (wr_dest),
        .rd_slot_i (rd_slot_w),
        .swap_i    (swap_w),
        .col_o     (col_w),
        .sel_o     (sel_w),
        .slot_o    (slot_w),
        .bound_o   (bound_w),
        .valid_o   (valid_w)
    );

    lbs_frame_checker #(.N_LC(N_LC), .N_GRP(N_GRP)) u_check (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (commit),
        .col_i     (col_w),
        .grp_i     (grp_w),
        .cap_i     (cap_w),
        .bound_i   (bound_w),
        .rd_slot_o (rd_slot_w),
        .busy_o    (busy_w),
        .err_o     (err_o),
        .swap_o    (swap_w)
    );

    // Flatten per-sender selects
    for (genvar s = 0; s < N_LC; s++) begin : g_sel
        assign sel_o[s*LW +: LW] = sel_w[s];
    end

    // Every select of an installed frame names an existing receiver
    always_comb begin
        sel_in_range = 1'b1;
        for (int s = 0; s < N_LC; s++) begin
            if (int'(sel_w[s]) >= N_LC) sel_in_range = 1'b0;
        end
    end

    assign slot_o        = slot_w;
    assign frame_start_o = (slot_w == '0);
    assign busy_o        = busy_w;
    assign valid_o       = valid_w;

    AST_SEL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_w |-> sel_in_range); // R5
    AST_NO_SWAP_WHILE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !busy_w) |=> $stable(valid_w) || !err_o); // R7

endmodule

// File: tb/lbs_frame_player_tb.sv
module lbs_frame_player_tb;

    localparam int N  = 6;
    localparam int G  = 3;
    localparam int LW = 3;
    localparam int GW = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [LW-1:0]   wr_slot = '0;
    logic [LW-1:0]   wr_sender = '0;
    logic [LW-1:0]   wr_dest = '0;
    logic            grp_wr_en = 1'b0;
    logic [LW-1:0]   grp_wr_lc = '0;
    logic [GW-1:0]   grp_wr_id = '0;
    logic            commit = 1'b0;
    logic [N*LW-1:0] sel_o;
    logic [LW-1:0]   slot_o;
    logic            frame_start_o;
    logic            busy_o;
    logic            valid_o;
    logic            err_o;

    int n_chk = 0;
    int n_err = 0;
    int fr     [N][N];   // [slot][sender]
    int act    [N][N];   // expected active frame
    int eg     [N];      // expected group of each linecard
    int exp_valid = 0;

    lbs_frame_player #(.N_LC(N), .N_GRP(G)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_slot(wr_slot),
        .wr_sender(wr_sender), .wr_dest(wr_dest), .grp_wr_en(grp_wr_en),
        .grp_wr_lc(grp_wr_lc), .grp_wr_id(grp_wr_id), .commit(commit),
        .sel_o(sel_o), .slot_o(slot_o), .frame_start_o(frame_start_o),
        .busy_o(busy_o), .valid_o(valid_o), .err_o(err_o)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int actual, input int expected);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d", req, actual, expected);
        end
    endtask

    function automatic int sel_of(input int s);
        return int'(sel_o[s*LW +: LW]);
    endfunction

    // Verdict from the requirements: Latin square plus group-pair caps
    function automatic bit frame_ok();
        int sz [G];
        for (int g = 0; g < G; g++) sz[g] = 0;
        for (int l = 0; l < N; l++) sz[eg[l]]++;
        for (int t = 0; t < N; t++) begin
            int used [N];
            int cnt [G][G];
            for (int r = 0; r < N; r++) used[r] = 0;
            for (int i = 0; i < G; i++) for (int j = 0; j < G; j++) cnt[i][j] = 0;
            for (int s = 0; s < N; s++) begin
                if (fr[t][s] >= N) return 1'b0;
                if (used[fr[t][s]] != 0) return 1'b0;
                used[fr[t][s]] = 1;
                cnt[eg[s]][eg[fr[t][s]]]++;
            end
            for (int i = 0; i < G; i++)
                for (int j = 0; j < G; j++)
                    if (cnt[i][j] > (sz[i] * sz[j] + N - 1) / N) return 1'b0;
        end
        for (int s = 0; s < N; s++) begin
            int hit [N];
            for (int r = 0; r < N; r++) hit[r] = 0;
            for (int t = 0; t < N; t++) hit[fr[t][s]]++;
            for (int r = 0; r < N; r++) if (hit[r] != 1) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic load_frame();
        for (int t = 0; t < N; t++) begin
            for (int s = 0; s < N; s++) begin
                @(negedge clk);
                wr_en = 1'b1; wr_slot = LW'(t); wr_sender = LW'(s); wr_dest = LW'(fr[t][s]);
            end
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load_groups();
        for (int l = 0; l < N; l++) begin
            @(negedge clk);
            grp_wr_en = 1'b1; grp_wr_lc = LW'(l); grp_wr_id = GW'(eg[l]);
        end
        // R6: id 3 is not a group and must be ignored
        @(negedge clk);
        grp_wr_en = 1'b1; grp_wr_lc = '0; grp_wr_id = GW'(3);
        @(negedge clk);
        grp_wr_en = 1'b0;
    endtask

    // Play one full frame and compare every select with the expected frame
    task automatic play_check();
        int prev;
        prev = int'(slot_o);
        for (int k = 0; k < N; k++) begin
            for (int s = 0; s < N; s++)
                chk(sel_of(s) == act[int'(slot_o)][s], "R3 select", sel_of(s), act[int'(slot_o)][s]);
            chk(frame_start_o == (slot_o == '0), "R2 frame start", int'(frame_start_o), int'(slot_o == '0));
            chk(int'(valid_o) == exp_valid, "R7 R8 valid", int'(valid_o), exp_valid);
            @(negedge clk);
            chk(int'(slot_o) == (prev + 1) % N, "R2 slot step", int'(slot_o), (prev + 1) % N);
            prev = int'(slot_o);
        end
    endtask

    // Commit, measure busy, check verdict; optionally poke inputs while busy
    task automatic run_commit(input bit intrude);
        bit exp_pass;
        int cnt;
        exp_pass = frame_ok();
        @(negedge clk);
        commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
        chk(err_o == 1'b0, "R7 err cleared on commit", int'(err_o), 0);
        cnt = 0;
        while (busy_o && cnt < 40) begin
            cnt++;
            if (intrude && cnt == 2) begin
                // R9: these must all be ignored
                wr_en = 1'b1; wr_slot = '0; wr_sender = '0; wr_dest = LW'((fr[0][0] + 1) % N);
                grp_wr_en = 1'b1; grp_wr_lc = LW'(1); grp_wr_id = GW'((eg[1] + 1) % G);
                commit = 1'b1;
            end else begin
                wr_en = 1'b0; grp_wr_en = 1'b0; commit = 1'b0;
            end
            @(negedge clk);
        end
        wr_en = 1'b0; grp_wr_en = 1'b0; commit = 1'b0;
        if (exp_pass) begin
            chk(err_o == 1'b0, "R5 R6 verdict pass", int'(err_o), 0);
            chk(cnt >= N && cnt <= 2 * N, "R4 busy span pass", cnt, N);
            chk(slot_o == '0, "R8 activation at wrap", int'(slot_o), 0);
            for (int t = 0; t < N; t++) for (int s = 0; s < N; s++) act[t][s] = fr[t][s];
            exp_valid = 1;
        end else begin
            chk(err_o == 1'b1, "R5 R6 verdict fail", int'(err_o), 1);
            chk(cnt == N, "R4 busy span fail", cnt, N);
        end
        play_check();
    endtask

    task automatic rotated(input int m, input int off);
        for (int t = 0; t < N; t++)
            for (int s = 0; s < N; s++)
                fr[t][s] = (m * s + t + off) % N;
    endtask

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        for (int t = 0; t < N; t++) for (int s = 0; s < N; s++) act[t][s] = 0;
        for (int l = 0; l < N; l++) eg[l] = 0;

        // R1: state under reset
        repeat (3) @(negedge clk);
        chk(!valid_o && !err_o && !busy_o, "R1 flags in reset", int'({valid_o, err_o, busy_o}), 0);
        chk(slot_o == '0, "R1 slot in reset", int'(slot_o), 0);
        chk(sel_o == '0, "R1 selects in reset", int'(sel_o), 0);
        rst_n = 1'b1;
        chk(slot_o == '0, "R1 slot after reset", int'(slot_o), 0);
        play_check();  // R3: zero frame before activation

        // Plain rotation, all in group 0: passes
        rotated(1, 0);
        load_frame();
        run_commit(1'b0);

        // R5: duplicate receiver within a slot
        rotated(5, 2);
        fr[2][1] = fr[2][0];
        load_frame();
        run_commit(1'b0);

        // R5: receiver code 6 is out of range
        rotated(1, 3);
        fr[4][3] = 6;
        load_frame();
        run_commit(1'b0);

        // R5: columns fine but slot 1 repeats slot 0, so rows repeat
        rotated(1, 0);
        for (int s = 0; s < N; s++) fr[1][s] = fr[0][s];
        load_frame();
        run_commit(1'b0);

        // R6: two groups of three, identity slot overloads group 0 to group 0
        for (int l = 0; l < N; l++) eg[l] = (l < 3) ? 0 : 1;
        load_groups();
        rotated(1, 0);
        load_frame();
        run_commit(1'b0);

        // R6 R9: sweep every membership of six linecards over three groups
        for (int code = 0; code < 729; code++) begin
            int c;
            c = code;
            for (int l = 0; l < N; l++) begin
                eg[l] = c % 3;
                c = c / 3;
            end
            rotated(((code % 2) != 0) ? 5 : 1, code % N);
            if (code % 11 == 0) fr[3][2] = fr[3][4];
            if (code % 13 == 0) fr[1][5] = 7;
            load_groups();
            load_frame();
            run_commit(1'b1);
        end

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule